// File: doc/BRIEF.md
# Power and Thermal Warning Register

This block is the warning and self-test register set of the slot-7 status interface. It watches three asynchronous inputs: a power-fail warning level from the supply, a high-temperature warning from the fan controller, and the self-test push button on the service panel. The host reads a status register to see whether power is failing or the machine has run hot. It writes a control register to acknowledge the thermal event, to enable self-test and to start self-test. Whenever a new warning arrives, an attention flag is raised so that the block answers the next I/O poll.

The two warnings are handled differently. Power-fail is reported live: the status bit follows the synchronised input and clears by itself when the supply recovers. High temperature is captured on its rising edge and held until software clears it, because the input may come and go. Self-test can start in three ways: automatically after reset, from a software command while enabled, or from a debounced button press while enabled. The start output is always a one-cycle pulse.

A shared 16-bit mailbox register sits at index 10. The host and the service processor can both write it and both read it back.

Top module: `pwr_warn_regs`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0 with both warnings low, the mailbox reads 0 on both sides, and poll_attn is low.
- R2: After reset is released, selftest_go pulses high for exactly one cycle, with no host or button action.
- R3: Status register (index 2) bit 1 follows the power-fail input after two-stage synchronisation and returns to 0 by itself when the input drops.
- R4: A rising edge of the synchronised power-fail input sets poll_attn.
- R5: A rising edge of the synchronised high-temperature input sets status bit 2, which stays 1 after the input falls.
- R6: A host write to the control register (index 1) with bit 1 = 1 clears status bit 2. A write with bit 1 = 0 leaves it set.
- R7: A rising edge of the high-temperature input sets poll_attn. poll_attn stays high until the host reads index 2, and it is low in the cycle after that read.
- R8: Control bit 2 is the self-test enable and reads back as written. All other control bits read 0.
- R9: A control write with bit 5 = 1 and bit 2 = 1 produces one selftest_go pulse. With bit 2 = 0 in that write, no pulse occurs and self-test is left disabled.
- R10: A button press held for at least DB_CYCLES (default 1024) cycles after synchronisation produces one selftest_go pulse, but only while the enable bit is set. Shorter presses, and presses made while the enable bit is clear, produce no pulse.
- R11: A write to index 10 from either the host or the service processor updates the mailbox, which both sides read. When both write in the same cycle, the host value is kept.
- R12: selftest_go is never high in two consecutive cycles. A trigger that arrives during a pulse is merged into that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 4 | Host register index |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (a read of index 2 acknowledges attention) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_sel (combinational) |
| sp_wr | input | 1 | Service processor mailbox write strobe |
| sp_wdata | input | 16 | Service processor mailbox write data |
| sp_rdata | output | 16 | Mailbox contents seen by the service processor |
| pfw_in | input | 1 | Asynchronous power-fail warning level |
| hot_in | input | 1 | Asynchronous high-temperature warning |
| btn_in | input | 1 | Asynchronous self-test panel button |
| poll_attn | output | 1 | Attention response for the I/O poll |
| selftest_go | output | 1 | One-cycle self-test start pulse |

## Verification
A table of control-register write values mixes the enable and start bits with every other bit set or clear. This separates a start that honours the enable carried in the same write from one that ignores it, and it confirms that undefined bits read back as zero. The warnings are driven as pulses that rise and then fall. The pulses show that the power-fail bit tracks its input while the thermal bit stays set until a write with bit 1 set, and that both raise attention that only a status read removes. Button presses of three kinds (shorter than the debounce window, long while enabled, and long while disabled) separate the debounce and enable gating. A simultaneous host and service-processor mailbox write exposes the write priority.

// File: rtl/pwr_warn_pkg.sv
package pwr_warn_pkg;

    localparam int REG_W = 16;
    localparam int IDX_W = 4;

    localparam logic [IDX_W-1:0] IDX_CTRL = 4'd1;
    localparam logic [IDX_W-1:0] IDX_STAT = 4'd2;
    localparam logic [IDX_W-1:0] IDX_MBOX = 4'd10;

    localparam int CTRL_HOT_CLR = 1;
    localparam int CTRL_EN      = 2;
    localparam int CTRL_START   = 5;
    localparam int STAT_PFW     = 1;
    localparam int STAT_HOT     = 2;

    typedef struct packed {
        logic pfw;
        logic hot;
    } warn_t;

    typedef struct packed {
        logic             wr;
        logic             rd;
        logic [IDX_W-1:0] idx;
        logic [REG_W-1:0] data;
    } host_op_t;

    function automatic logic hits(host_op_t op, logic [IDX_W-1:0] idx, logic is_wr);
        return (is_wr ? op.wr : op.rd) && (op.idx == idx);
    endfunction

    function automatic logic [REG_W-1:0] stat_word(warn_t s);
        logic [REG_W-1:0] w;
        w = '0;
        w[STAT_PFW] = s.pfw;
        w[STAT_HOT] = s.hot;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_word(logic en);
        logic [REG_W-1:0] w;
        w = '0;
        w[CTRL_EN] = en;
        return w;
    endfunction

endpackage

// File: rtl/pwr_warn_sync.sv
module pwr_warn_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pwr_warn_debounce.sv
module pwr_warn_debounce #(
    parameter int CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            clean <= 1'b0;
        end else if (raw == clean) begin
            cnt <= '0;
        end else if (cnt == CW'(CYCLES - 1)) begin
            cnt   <= '0;
            clean <= raw;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwr_warn_events.sv
module pwr_warn_events
    import pwr_warn_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  warn_t lvl,
    input  logic  hot_clr,
    input  logic  attn_ack,
    output warn_t stat,
    output logic  attn
);
    warn_t prev;
    warn_t rise;
    logic  hot_flag;

    assign rise = lvl & ~prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev     <= '0;
            hot_flag <= 1'b0;
            attn     <= 1'b0;
        end else begin
            prev     <= lvl;
            hot_flag <= rise.hot | (hot_flag & ~hot_clr);
            attn     <= rise.pfw | rise.hot | (attn & ~attn_ack);
        end
    end

    always_comb begin
        stat.pfw = lvl.pfw;
        stat.hot = hot_flag;
    end
endmodule

// File: rtl/pwr_warn_regs.sv
module pwr_warn_regs
    import pwr_warn_pkg::*;
#(
    parameter int DB_CYCLES   = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] host_sel,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [REG_W-1:0] host_wdata,
    output logic [REG_W-1:0] host_rdata,
    input  logic             sp_wr,
    input  logic [REG_W-1:0] sp_wdata,
    output logic [REG_W-1:0] sp_rdata,
    input  logic             pfw_in,
    input  logic             hot_in,
    input  logic             btn_in,
    output logic             poll_attn,
    output logic             selftest_go
);
    localparam int NSYNC = 3;

    host_op_t         op;
    logic [NSYNC-1:0] sync_q;
    warn_t            lvl;
    warn_t            stat;
    logic             btn_s, btn_db, btn_db_q;
    logic             en_q, por_q, go_q;
    logic [REG_W-1:0] mbox_q;
    logic             ctrl_wr, sw_go, btn_go;

    always_comb begin
        op.wr   = host_wr;
        op.rd   = host_rd;
        op.idx  = host_sel;
        op.data = host_wdata;
    end

    pwr_warn_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({btn_in, hot_in, pfw_in}),
        .q   (sync_q)
    );

    always_comb begin
        lvl.pfw = sync_q[0];
        lvl.hot = sync_q[1];
        btn_s   = sync_q[2];
    end

    pwr_warn_debounce #(.CYCLES(DB_CYCLES)) u_db (
        .clk   (clk),
        .rst   (rst),
        .raw   (btn_s),
        .clean (btn_db)
    );

    assign ctrl_wr = hits(op, IDX_CTRL, 1'b1);

    pwr_warn_events u_evt (
        .clk      (clk),
        .rst      (rst),
        .lvl      (lvl),
        .hot_clr  (ctrl_wr & op.data[CTRL_HOT_CLR]),
        .attn_ack (hits(op, IDX_STAT, 1'b0)),
        .stat     (stat),
        .attn     (poll_attn)
    );

    assign sw_go  = ctrl_wr & op.data[CTRL_START] & op.data[CTRL_EN];
    assign btn_go = btn_db & ~btn_db_q & en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            por_q    <= 1'b1;
            go_q     <= 1'b0;
            btn_db_q <= 1'b0;
            mbox_q   <= '0;
        end else begin
            por_q    <= 1'b0;
            btn_db_q <= btn_db;
            go_q     <= (por_q | sw_go | btn_go) & ~go_q;
            if (ctrl_wr) en_q <= op.data[CTRL_EN];
            if (hits(op, IDX_MBOX, 1'b1)) mbox_q <= op.data;
            else if (sp_wr)               mbox_q <= sp_wdata;
        end
    end

    always_comb begin
        case (op.idx)
            IDX_CTRL: host_rdata = ctrl_word(en_q);
            IDX_STAT: host_rdata = stat_word(stat);
            IDX_MBOX: host_rdata = mbox_q;
            default:  host_rdata = '0;
        endcase
    end

    assign sp_rdata    = mbox_q;
    assign selftest_go = go_q;
endmodule

// File: rtl/pwr_warn_chk.sv
module pwr_warn_chk
    import pwr_warn_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [IDX_W-1:0] host_sel,
    input logic             host_wr,
    input logic             host_rd,
    input logic [REG_W-1:0] host_wdata,
    input logic [REG_W-1:0] host_rdata,
    input logic [REG_W-1:0] sp_rdata,
    input logic             pfw_in,
    input logic             poll_attn,
    input logic             selftest_go,
    input logic             hot_flag
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 2'd3) age <= age + 1'b1;
    end

    p_go_single_r12: assert property (@(posedge clk) disable iff (rst)
        selftest_go |=> !selftest_go);

    p_attn_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (poll_attn && !(host_rd && host_sel == IDX_STAT)) |=> poll_attn);

    p_hot_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (hot_flag && !(host_wr && host_sel == IDX_CTRL && host_wdata[CTRL_HOT_CLR]))
        |=> hot_flag);

    p_mbox_write_r11: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_sel == IDX_MBOX) |=> (sp_rdata == $past(host_wdata)));

    p_pfw_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && !$past(pfw_in) && !$past(pfw_in, 2) && !$past(pfw_in, 3)
         && host_sel == IDX_STAT) |-> !host_rdata[STAT_PFW]);
endmodule

bind pwr_warn_regs pwr_warn_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_sel    (host_sel),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .sp_rdata    (sp_rdata),
    .pfw_in      (pfw_in),
    .poll_attn   (poll_attn),
    .selftest_go (selftest_go),
    .hot_flag    (u_evt.hot_flag)
);

// File: tb/pwr_warn_regs_test.sv
module pwr_warn_regs_test;
    localparam time PERIOD = 10ns;
    localparam int  DB     = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  host_sel = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        sp_wr = 1'b0;
    logic [15:0] sp_wdata = '0;
    logic [15:0] sp_rdata;
    logic        pfw_in = 1'b0, hot_in = 1'b0, btn_in = 1'b0;
    logic        poll_attn, selftest_go;

    int total = 0, bad = 0, go_cnt = 0, adj = 0;
    logic go_prev = 1'b0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    pwr_warn_regs #(.DB_CYCLES(DB)) uut (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .sp_wr(sp_wr), .sp_wdata(sp_wdata),
        .sp_rdata(sp_rdata), .pfw_in(pfw_in), .hot_in(hot_in), .btn_in(btn_in),
        .poll_attn(poll_attn), .selftest_go(selftest_go)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (selftest_go) go_cnt++;
            if (selftest_go && go_prev) adj++;
            go_prev <= selftest_go;
        end
    end

    // Each entry: control write value, expected pulse count, expected readback
    localparam logic [32:0] VEC [6] = '{
        {16'h0020, 1'b0, 16'h0000},
        {16'h0024, 1'b1, 16'h0004},
        {16'h0004, 1'b0, 16'h0004},
        {16'hFFFF, 1'b1, 16'h0004},
        {16'h0020, 1'b0, 16'h0000},
        {16'h0000, 1'b0, 16'h0000}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hwrite(logic [3:0] sel, logic [15:0] d);
        @(negedge clk);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(logic [3:0] sel, output logic [15:0] d);
        @(negedge clk);
        host_sel = sel; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic press(int n);
        @(negedge clk);
        btn_in = 1'b1;
        cyc(n);
        btn_in = 1'b0;
        cyc(DB + 20);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int g0;
        cyc(3);
        rst = 1'b0;
        cyc(4);
        chk("R2 power-up pulse", go_cnt, 1);
        hread(4'd1, d);  chk("R1 ctrl reset", d, 0);
        chk("R1 attn reset", poll_attn, 0);
        hread(4'd2, d);  chk("R1 stat reset", d, 0);
        hread(4'd10, d); chk("R1 mbox reset", d, 0);
        chk("R1 sp mbox reset", sp_rdata, 0);

        for (int i = 0; i < 6; i++) begin
            g0 = go_cnt;
            hwrite(4'd1, VEC[i][32:17]);
            cyc(1);
            chk("R9 sw start pulse", go_cnt - g0, VEC[i][16]);
            hread(4'd1, d);
            chk("R8 ctrl readback", d, VEC[i][15:0]);
        end

        // power-fail: live level, attention
        @(negedge clk) pfw_in = 1'b1;
        cyc(5);
        chk("R4 pfw attn", poll_attn, 1);
        hread(4'd2, d);  chk("R3 pfw bit set", d, 16'h0002);
        chk("R7 attn cleared by read", poll_attn, 0);
        @(negedge clk) pfw_in = 1'b0;
        cyc(5);
        hread(4'd2, d);  chk("R3 pfw bit self clears", d, 16'h0000);
        chk("R4 no attn on fall", poll_attn, 0);

        // high temperature: sticky
        @(negedge clk) hot_in = 1'b1;
        cyc(5);
        @(negedge clk) hot_in = 1'b0;
        cyc(5);
        chk("R7 hot attn held", poll_attn, 1);
        hread(4'd2, d);  chk("R5 hot sticky", d, 16'h0004);
        chk("R7 attn cleared by read", poll_attn, 0);
        hwrite(4'd1, 16'h0000);
        hread(4'd2, d);  chk("R6 zero write keeps hot", d, 16'h0004);
        hwrite(4'd1, 16'h0002);
        hread(4'd2, d);  chk("R6 clear hot", d, 16'h0000);

        // button
        hwrite(4'd1, 16'h0004);
        g0 = go_cnt;
        press(DB / 2);
        chk("R10 short press ignored", go_cnt - g0, 0);
        g0 = go_cnt;
        press(DB + 20);
        chk("R10 long press pulse", go_cnt - g0, 1);
        hwrite(4'd1, 16'h0000);
        g0 = go_cnt;
        press(DB + 20);
        chk("R10 press while disabled", go_cnt - g0, 0);

        // mailbox
        @(negedge clk) begin sp_wr = 1'b1; sp_wdata = 16'hBEEF; end
        @(negedge clk) sp_wr = 1'b0;
        hread(4'd10, d); chk("R11 sp write seen by host", d, 16'hBEEF);
        hwrite(4'd10, 16'h1234);
        chk("R11 host write seen by sp", sp_rdata, 16'h1234);
        @(negedge clk) begin
            sp_wr = 1'b1; sp_wdata = 16'h5555;
            host_sel = 4'd10; host_wdata = 16'hAAAA; host_wr = 1'b1;
        end
        @(negedge clk) begin sp_wr = 1'b0; host_wr = 1'b0; end
        chk("R11 host priority", sp_rdata, 16'hAAAA);

        // back-to-back start writes merge
        hwrite(4'd1, 16'h0024);
        hwrite(4'd1, 16'h0024);
        cyc(2);
        chk("R12 no adjacent pulses", adj, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule